// File: doc/BRIEF.md
# JTAG TAP Instruction and Data Register Shifter

This block drives the test access port of a target device on its own. It produces every TMS pattern needed to walk the TAP state machine, so the command source never supplies TMS values. Three operations are available. The first returns the TAP to Run-Test/Idle from any state. The second shifts a fixed 8-bit instruction register. The third shifts a data register whose length is chosen per command. Every shift sends back the bits captured out of the target.

Commands arrive as a byte stream over a valid/ready handshake: an opcode byte, then that operation's parameter bytes. Results leave as a byte stream over a second valid/ready handshake.

Each TCK period is built from system clocks. The high phase lasts `TCK_HALF` clocks and the low phase lasts at least that long. TMS and TDI change only while TCK is low. TDO is sampled at the moment TCK rises. When the response side stalls, TCK stops low until the pending byte is taken.

Top module: `jtag_ir_dr_engine`

## Requirements
- R1: Opcode byte 0x01 drives TMS high for `RESET_ONES` (default 5, at least 5) TCK rising edges and then low for one, leaving the TAP in Run-Test/Idle from any starting state; it takes no parameter and returns no byte.
- R2: Opcode byte 0x02 takes one parameter byte, shifts exactly 8 instruction-register bits with bit 0 first, and returns one byte holding the instruction register contents captured before the shift. The walk uses TMS 1,1,0,0, then 8 shift clocks with TMS high on the last one, then TMS 1,0, which is 14 rising edges in total.
- R3: Opcode byte 0x03 takes a bit-count byte N, then ceil(N/8) value bytes. Bit i of the value is bit i%8 of byte i/8, and bits shift in from bit 0 upward. The block returns ceil(N/8) bytes of captured bits in the same packing, with unused upper bits of the last byte zero.
- R4: A data-register count of zero consumes no further bytes, returns no byte and produces no TCK edge.
- R5: Every operation ends with the TAP in Run-Test/Idle. A data-register shift of N bits uses TMS 1,0,0, then N shift clocks with TMS high on the last one, then TMS 1,0, which is N+5 rising edges.
- R6: TCK rests low. Each high phase lasts exactly `TCK_HALF` clocks, and TMS and TDI stay constant while TCK is high.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds its value and TCK makes no rising edge.
- R8: An opcode byte other than 0x01, 0x02 or 0x03 is consumed and dropped, with no TCK edge and no response byte.
- R9: After reset, TCK is low, `rsp_valid` is low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command byte accepted on this clock |
| cmd_data | input | 8 | Opcode or parameter byte |
| rsp_valid | output | 1 | Result byte available |
| rsp_ready | input | 1 | Result byte taken on this clock |
| rsp_data | output | 8 | Captured bits, LSB first |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target |

## Verification
A result byte becomes valid one clock after the falling edge of TCK that ends the byte's last shift bit. Its timing therefore depends on `TCK_HALF`, so the bench does not count a fixed delay: it polls `rsp_valid` and `cmd_ready` at falling system-clock edges and completes each handshake on the following rising edge. The two closing TMS bits finish within about 2*(2*`TCK_HALF`+2) clocks after the last result byte. The bench therefore waits a fixed 40 clocks, which covers that window, before it reads the behavioural TAP model's state and its count of TCK rising edges. TCK high-phase length and TMS/TDI stability are monitored on every falling system-clock edge for the whole run.

// File: rtl/jtag_eng_pkg.sv
package jtag_eng_pkg;

  typedef enum logic [7:0] {
    OP_RESET = 8'h01,
    OP_IR    = 8'h02,
    OP_DR    = 8'h03
  } jop_e;

  localparam logic [1:0] K_RST = 2'd0;
  localparam logic [1:0] K_IR  = 2'd1;
  localparam logic [1:0] K_DR  = 2'd2;

  typedef enum logic [2:0] {
    C_OP, C_CNT, C_PRE, C_LOAD, C_SHIFT, C_EMIT, C_POST
  } cst_e;

  typedef enum logic [1:0] {
    E_IDLE, E_LOW, E_HIGH
  } est_e;

  // number of TMS steps before the first shift bit (or the whole reset walk)
  function automatic logic [3:0] pre_len(input logic [1:0] kind, input logic [3:0] ones);
    case (kind)
      K_RST:   pre_len = ones + 4'd1;
      K_IR:    pre_len = 4'd4;
      default: pre_len = 4'd3;
    endcase
  endfunction

  // TMS level for preamble step idx
  function automatic logic pre_tms(input logic [1:0] kind, input logic [3:0] idx,
                                   input logic [3:0] ones);
    case (kind)
      K_RST:   pre_tms = (idx < ones);
      K_IR:    pre_tms = (idx < 4'd2);
      default: pre_tms = (idx == 4'd0);
    endcase
  endfunction

  // bits carried by the next packed byte
  function automatic logic [3:0] byte_bits(input logic [8:0] rem);
    byte_bits = (rem >= 9'd8) ? 4'd8 : rem[3:0];
  endfunction

endpackage

// File: rtl/jtag_bit_engine.sv
module jtag_bit_engine #(
  parameter int TCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_tms,
  input  logic go_tdi,
  output logic done,
  output logic tdo_bit,
  output logic tck,
  output logic tms,
  output logic tdi,
  input  logic tdo
);
  import jtag_eng_pkg::*;

  localparam int CW = (TCK_HALF > 1) ? $clog2(TCK_HALF) : 1;
  localparam logic [CW-1:0] CMAX = CW'(TCK_HALF - 1);

  est_e          st;
  logic [CW-1:0] cnt;
  wire           phase_end = (cnt == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      cnt     <= '0;
      tck     <= 1'b0;
      tms     <= 1'b0;
      tdi     <= 1'b0;
      tdo_bit <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: if (go) begin
          tms <= go_tms;
          tdi <= go_tdi;
          cnt <= '0;
          st  <= E_LOW;
        end
        E_LOW: if (phase_end) begin
          tck     <= 1'b1;
          tdo_bit <= tdo;
          cnt     <= '0;
          st      <= E_HIGH;
        end else cnt <= cnt + 1'b1;
        E_HIGH: if (phase_end) begin
          tck  <= 1'b0;
          done <= 1'b1;
          cnt  <= '0;
          st   <= E_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= E_IDLE;
      endcase
    end
  end

  // R6: sequencer only requests a bit while the engine is free
  p_go_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st == E_IDLE));

  // R6: target lines frozen during the high phase
  p_lines_stable_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));

endmodule

// File: rtl/jtag_seq_ctrl.sv
module jtag_seq_ctrl #(
  parameter int RESET_ONES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_data,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       bit_go,
  output logic       bit_tms,
  output logic       bit_tdi,
  input  logic       bit_done,
  input  logic       bit_tdo
);
  import jtag_eng_pkg::*;

  localparam logic [3:0] ONES = 4'(RESET_ONES);

  cst_e       st;
  logic [1:0] kind;
  logic [3:0] idx;
  logic [8:0] rem;
  logic [3:0] nb;
  logic [3:0] bpos;
  logic [7:0] sh_in;
  logic [7:0] sh_out;
  logic       pend;

  // named internal events
  wire cmd_take  = cmd_valid && cmd_ready;
  wire rsp_take  = rsp_valid && rsp_ready;
  wire in_walk   = (st == C_PRE) || (st == C_SHIFT) || (st == C_POST);
  wire pre_last  = (idx == pre_len(kind, ONES) - 4'd1);
  wire byte_last = (bpos == nb - 4'd1);
  wire post_last = (idx == 4'd1);

  assign cmd_ready = (st == C_OP) || (st == C_CNT) || (st == C_LOAD);
  assign rsp_valid = (st == C_EMIT);
  assign rsp_data  = sh_out;
  assign bit_go    = in_walk && !pend;

  always_comb begin
    bit_tms = 1'b0;
    bit_tdi = 1'b0;
    case (st)
      C_PRE:   bit_tms = pre_tms(kind, idx, ONES);
      C_SHIFT: begin
        bit_tms = (rem == 9'd1);
        bit_tdi = sh_in[bpos[2:0]];
      end
      C_POST:  bit_tms = (idx == 4'd0);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= C_OP;
      kind   <= K_RST;
      idx    <= '0;
      rem    <= '0;
      nb     <= '0;
      bpos   <= '0;
      sh_in  <= '0;
      sh_out <= '0;
      pend   <= 1'b0;
    end else begin
      if (bit_go)   pend <= 1'b1;
      if (bit_done) pend <= 1'b0;
      case (st)
        C_OP: if (cmd_take) begin
          idx <= '0;
          case (cmd_data)
            OP_RESET: begin kind <= K_RST; st <= C_PRE; end
            OP_IR:    begin kind <= K_IR; rem <= 9'd8; st <= C_PRE; end
            OP_DR:    st <= C_CNT;
            default:  st <= C_OP;
          endcase
        end
        C_CNT: if (cmd_take) begin
          rem  <= {1'b0, cmd_data};
          kind <= K_DR;
          st   <= (cmd_data == 8'd0) ? C_OP : C_PRE;
        end
        C_PRE: if (bit_done) begin
          if (pre_last) begin
            idx <= '0;
            st  <= (kind == K_RST) ? C_OP : C_LOAD;
          end else idx <= idx + 4'd1;
        end
        C_LOAD: if (cmd_take) begin
          sh_in  <= cmd_data;
          sh_out <= '0;
          bpos   <= '0;
          nb     <= byte_bits(rem);
          st     <= C_SHIFT;
        end
        C_SHIFT: if (bit_done) begin
          sh_out[bpos[2:0]] <= bit_tdo;
          rem <= rem - 9'd1;
          if (byte_last) st <= C_EMIT;
          else bpos <= bpos + 4'd1;
        end
        C_EMIT: if (rsp_take) begin
          idx <= '0;
          st  <= (rem == 9'd0) ? C_POST : C_LOAD;
        end
        C_POST: if (bit_done) begin
          if (post_last) st <= C_OP;
          else idx <= idx + 4'd1;
        end
        default: st <= C_OP;
      endcase
    end
  end

  // R7: an offered result byte is held until taken
  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R3: a completed shift bit always belongs to a pending count
  p_done_has_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_SHIFT && bit_done) |-> (rem != 9'd0));

endmodule

// File: rtl/jtag_ir_dr_engine.sv
module jtag_ir_dr_engine #(
  parameter int TCK_HALF   = 2,
  parameter int RESET_ONES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_data,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       tck,
  output logic       tms,
  output logic       tdi,
  input  logic       tdo
);

  logic bit_go, bit_tms, bit_tdi, bit_done, bit_tdo;

  jtag_seq_ctrl #(.RESET_ONES(RESET_ONES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .bit_go(bit_go), .bit_tms(bit_tms), .bit_tdi(bit_tdi),
    .bit_done(bit_done), .bit_tdo(bit_tdo)
  );

  jtag_bit_engine #(.TCK_HALF(TCK_HALF)) u_bit (
    .clk(clk), .rst_n(rst_n),
    .go(bit_go), .go_tms(bit_tms), .go_tdi(bit_tdi),
    .done(bit_done), .tdo_bit(bit_tdo),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  // R7: the target clock stalls while a result byte waits
  p_no_tck_rise_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> !$rose(tck));

  // R4: TCK rests low whenever command bytes are awaited
  p_tck_low_at_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !tck);

endmodule

// File: tb/test_jtag_ir_dr_engine.sv
module test_jtag_ir_dr_engine;
  localparam int HALF = 2;
  localparam logic [63:0] CAP = 64'hA5C3_1E7F_0912_B46D;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, rsp_ready = 0;
  logic [7:0] cmd_data = 0;
  logic cmd_ready, rsp_valid, tck, tms, tdi;
  logic [7:0] rsp_data;
  logic tdo = 0;

  always #10 clk = ~clk;

  jtag_ir_dr_engine #(.TCK_HALF(HALF), .RESET_ONES(5)) i_jtag_ir_dr_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo));

  // ---------------- behavioural TAP model ----------------
  typedef enum logic [3:0] {TLR, IDLE, SELDR, CAPDR, SHDR, EX1DR, PAUDR, EX2DR, UPDDR,
                            SELIR, CAPIR, SHIR, EX1IR, PAUIR, EX2IR, UPDIR} tap_e;
  tap_e ts = PAUDR;
  logic [63:0] dr_sh = 0;
  logic [7:0]  ir_sh = 0, ir_reg = 8'h5A;
  logic        tdi_log [0:511];
  int          dr_n = 0, rises = 0;

  function automatic tap_e tap_next(tap_e s, logic m);
    case (s)
      TLR:   return m ? TLR   : IDLE;
      IDLE:  return m ? SELDR : IDLE;
      SELDR: return m ? SELIR : CAPDR;
      CAPDR: return m ? EX1DR : SHDR;
      SHDR:  return m ? EX1DR : SHDR;
      EX1DR: return m ? UPDDR : PAUDR;
      PAUDR: return m ? EX2DR : PAUDR;
      EX2DR: return m ? UPDDR : SHDR;
      UPDDR: return m ? SELDR : IDLE;
      SELIR: return m ? TLR   : CAPIR;
      CAPIR: return m ? EX1IR : SHIR;
      SHIR:  return m ? EX1IR : SHIR;
      EX1IR: return m ? UPDIR : PAUIR;
      PAUIR: return m ? EX2IR : PAUIR;
      EX2IR: return m ? UPDIR : SHIR;
      default: return m ? SELDR : IDLE;
    endcase
  endfunction

  always @(posedge tck) begin
    rises <= rises + 1;
    case (ts)
      CAPDR: dr_sh <= CAP;
      SHDR: begin dr_sh <= {tdi, dr_sh[63:1]}; tdi_log[dr_n] <= tdi; dr_n <= dr_n + 1; end
      CAPIR: ir_sh <= ir_reg;
      SHIR:  ir_sh <= {tdi, ir_sh[7:1]};
      UPDIR: ir_reg <= ir_sh;
      default: ;
    endcase
    ts <= tap_next(ts, tms);
  end

  always @(negedge tck)
    tdo <= (ts == SHDR) ? dr_sh[0] : (ts == SHIR) ? ir_sh[0] : 1'b0;

  // ---------------- line monitor (R6) ----------------
  int viol = 0, hi_bad = 0, hi_cnt = 0;
  logic p_tck = 0, p_tms = 0, p_tdi = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tck && p_tck && (tms !== p_tms || tdi !== p_tdi)) viol++;
      if (tck) hi_cnt++;
      else if (p_tck) begin
        if (hi_cnt != HALF) hi_bad++;
        hi_cnt = 0;
      end
    end
    p_tck = tck; p_tms = tms; p_tdi = tdi;
  end

  // ---------------- bookkeeping ----------------
  int vec = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    vec++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1; cmd_data = b;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic recv(output logic [7:0] b);
    @(negedge clk);
    rsp_ready = 1;
    while (!rsp_valid) @(negedge clk);
    b = rsp_data;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    @(negedge clk);
    chk(tck == 0, "R9 tck low", 64'(tck), 0);
    chk(rsp_valid == 0, "R9 rsp_valid low", 64'(rsp_valid), 0);
    chk(cmd_ready == 1, "R9 cmd_ready high", 64'(cmd_ready), 1);
  endtask

  task automatic t_bad_op();
    int r0 = rises;
    bit saw = 0;
    send(8'h7E);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (rsp_valid) saw = 1; end
    chk(rises == r0, "R8 no tck on unknown opcode", 64'(rises - r0), 0);
    chk(!saw && cmd_ready, "R8 no response, ready again", 64'(saw), 0);
  endtask

  task automatic t_tap_reset();
    int r0 = rises;
    send(8'h01);
    settle();
    chk(ts == IDLE, "R1 reset reaches Run-Test/Idle", 64'(ts), 64'(IDLE));
    chk(rises - r0 == 6, "R1 reset edge count", 64'(rises - r0), 6);
  endtask

  task automatic t_ir(input logic [7:0] nv, input logic [7:0] exp);
    logic [7:0] got;
    int r0 = rises;
    send(8'h02); send(nv); recv(got);
    settle();
    chk(got == exp, "R2 IR returns previous contents", 64'(got), 64'(exp));
    chk(ir_reg == nv, "R2 IR loaded with new byte", 64'(ir_reg), 64'(nv));
    chk(rises - r0 == 14, "R2 IR edge count", 64'(rises - r0), 14);
    chk(ts == IDLE, "R5 IR ends in Idle", 64'(ts), 64'(IDLE));
  endtask

  task automatic t_dr(input int n, input logic [63:0] val);
    logic [7:0] got, exp;
    int r0 = rises, base = dr_n, nbytes = (n + 7) / 8, bad = 0;
    send(8'h03); send(8'(n));
    for (int k = 0; k < nbytes; k++) begin
      send(val[8*k +: 8]);
      recv(got);
      exp = 0;
      for (int j = 0; j < 8; j++) if (8*k + j < n) exp[j] = CAP[8*k + j];
      chk(got == exp, $sformatf("R3 DR n=%0d byte %0d", n, k), 64'(got), 64'(exp));
    end
    settle();
    for (int i = 0; i < n; i++) if (tdi_log[base + i] !== val[i]) bad++;
    chk(bad == 0, "R3 DR bits shifted LSB first", 64'(bad), 0);
    chk(rises - r0 == n + 5, "R5 DR edge count", 64'(rises - r0), 64'(n + 5));
    chk(ts == IDLE, "R5 DR ends in Idle", 64'(ts), 64'(IDLE));
  endtask

  task automatic t_dr_zero();
    int r0 = rises;
    bit saw = 0;
    send(8'h03); send(8'h00);
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (rsp_valid) saw = 1; end
    chk(rises == r0, "R4 zero count makes no tck edge", 64'(rises - r0), 0);
    chk(!saw && cmd_ready, "R4 zero count returns nothing", 64'(saw), 0);
    // the following opcode must be decoded as an opcode
    t_tap_reset();
  endtask

  task automatic t_backpressure();
    logic [7:0] held, got;
    int r0;
    bit moved = 0;
    send(8'h02); send(8'h96);
    while (!rsp_valid) @(negedge clk);
    held = rsp_data; r0 = rises;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_data != held) moved = 1;
    end
    chk(!moved, "R7 response held under backpressure", 64'(rsp_data), 64'(held));
    chk(rises == r0, "R7 tck stalled under backpressure", 64'(rises - r0), 0);
    recv(got);
    settle();
    chk(got == 8'hC1, "R7 held byte correct", 64'(got), 64'h C1);
    chk(ts == IDLE, "R5 ends in Idle after stall", 64'(ts), 64'(IDLE));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_state();
    t_bad_op();
    t_tap_reset();
    t_ir(8'h3C, 8'h5A);
    t_ir(8'hC1, 8'h3C);
    t_dr(12, 64'h0000_0000_0000_0B2D);
    t_dr(8,  64'h0000_0000_0000_00E4);
    t_dr(20, 64'h0000_0000_000F_3A71);
    t_dr(64, 64'h1357_9BDF_2468_ACE0);
    t_dr_zero();
    t_backpressure();
    chk(viol == 0, "R6 TMS/TDI stable while TCK high", 64'(viol), 0);
    chk(hi_bad == 0, "R6 TCK high phase length", 64'(hi_bad), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vec++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
      $finish;
    end
  end

endmodule